// File: doc/BRIEF.md
# Sectioned Register Access Sequencer

This block sits behind a serial bus front end that has already turned bus traffic into byte-level events. These events are a start carrying the device address byte, a word address, a write data byte, a read request, a valid stop, and an abort. The block manages a 64-byte register space. Five sections are populated: two alarm banks, a control bank, a time bank and a single status byte. Every other address is unpopulated.

The block keeps an address pointer that persists between transactions and steps after every byte served. The pointer wraps inside the section it is in. The status byte is handled inside the block and holds two write-enable bits that must be set in two steps. Write bytes for the other sections go into a slot buffer. The buffer is handed to storage in one parallel commit, but only when a valid stop closes the transaction and the second enable bit is set. Reads fetch from external storage through a combinational address/data pair. The block returns zero for unpopulated addresses and the enable bits for the status byte.

Top module: `ccr_seq`

## Requirements
- R1: A start whose device byte has bits [7:1] equal to 7'b1101111 selects the block, and bit 0 gives the direction (1 = read, 0 = write). After a start with any other device byte, every event is ignored until the next start.
- R2: Sections are 0x00-0x07, 0x08-0x0F, 0x10-0x13, 0x30-0x37 and 0x3F. A byte served at a section's last address moves the pointer to that section's first address. At an unpopulated address the pointer steps by one, modulo 64.
- R3: The pointer persists across transactions. After each read or write byte it holds the next address, so a read with no word address continues from there. A word address is taken only in a write transaction.
- R4: In a transaction, the first byte served at 0x3F is the only one. Later write bytes are ignored, later read requests give no rd_valid_o, and the pointer does not move.
- R5: A write to a section other than status commits only if the RWEL bit is set when the stop arrives. Otherwise the buffered bytes are discarded.
- R6: commit_o pulses for one cycle, one cycle after the stop is accepted. commit_base_o is the section base. Bit i of commit_mask_o marks address base+i, whose byte is commit_data_o[8i+7:8i]. Unwritten slots read 0. A slot written twice keeps its last byte.
- R7: A status write takes effect at the stop with no enable check. A status read returns {5'b0, RWEL, WEL, 1'b0}. Status never appears on the commit outputs.
- R8: A status write sets WEL to data bit 1. It sets RWEL only if data bits 1 and 2 are both 1 and WEL was already 1. Thus 0x02 then 0x06 sets both, 0x06 from the cleared state gives 0x02, and 0x00 clears both.
- R9: An abort discards the buffer and any pending status byte, and it ends the transaction. An abort in the same cycle as a stop wins, so nothing commits.
- R10: Write bytes at unpopulated addresses are dropped, and reads there return 0x00.
- R11: After reset the pointer is 0x00, WEL and RWEL are 0, and commit_o and rd_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start event with device byte |
| dev_i | input | 8 | Device address byte for start |
| addr_valid_i | input | 1 | Word address event |
| addr_i | input | AW | Word address |
| wdata_valid_i | input | 1 | Write data byte event |
| wdata_i | input | DW | Write data byte |
| rd_req_i | input | 1 | Read byte request |
| stop_i | input | 1 | Valid stop event |
| abort_i | input | 1 | Abort event, transaction discarded |
| mem_raddr_o | output | AW | Storage read address (current pointer) |
| mem_rdata_i | input | DW | Storage read data, combinational |
| rd_valid_o | output | 1 | Read byte valid |
| rd_data_o | output | DW | Read byte |
| commit_o | output | 1 | Commit pulse toward storage |
| commit_base_o | output | AW | Base address of committed section |
| commit_mask_o | output | SLOTS | Per-slot write mask |
| commit_data_o | output | SLOTS*DW | Per-slot data bytes |

## Verification
Termination and commit can fall in the same cycle: an abort arriving together with the stop of a fully enabled write. The bench drives both strobes on one edge after enabling writes, then expects commit_o to stay low. A following normal write must still commit, which shows the abort cleared state rather than wedging it. Pointer wrap and the one-byte status limit also interact, because the status section wraps onto itself. A second status byte is sent, and the bench judges it by the status value read back afterwards and by the missing rd_valid_o.

// File: rtl/ccr_seq_pkg.sv
package ccr_seq_pkg;
  localparam int unsigned NSEC     = 5;
  localparam int unsigned STAT_IDX = 4;
  localparam logic [6:0]  DEV_ID   = 7'b1101111;

  function automatic int unsigned sec_base(int unsigned i);
    case (i)
      0: return 0;
      1: return 8;
      2: return 16;
      3: return 48;
      default: return 63;
    endcase
  endfunction

  function automatic int unsigned sec_size(int unsigned i);
    case (i)
      2: return 4;
      4: return 1;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/ccr_sec_decode.sv
module ccr_sec_decode
  import ccr_seq_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned SW = 3
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic          is_stat_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] next_o,
  output logic [SW-1:0] off_o
);
  logic [NSEC-1:0] hit_v;
  logic [AW-1:0]   base_v [NSEC];
  logic [AW-1:0]   last_v [NSEC];

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    localparam int unsigned B = sec_base(g);
    localparam int unsigned S = sec_size(g);
    assign base_v[g] = AW'(B);
    assign last_v[g] = AW'(B + S - 1);
    // modular difference rejects addresses below the base
    assign hit_v[g]  = (addr_i - AW'(B)) < AW'(S);
  end

  always_comb begin
    hit_o  = |hit_v;
    base_o = addr_i;
    next_o = addr_i + AW'(1);
    for (int i = 0; i < NSEC; i++) begin
      if (hit_v[i]) begin
        base_o = base_v[i];
        next_o = (addr_i == last_v[i]) ? base_v[i] : addr_i + AW'(1);
      end
    end
  end

  assign is_stat_o = hit_v[STAT_IDX];
  assign off_o     = SW'(addr_i - base_o);
endmodule

// File: rtl/ccr_wr_buf.sv
module ccr_wr_buf #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned SW    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                we_i,
  input  logic [SW-1:0]       slot_i,
  input  logic [DW-1:0]       data_i,
  output logic [SLOTS-1:0]    mask_o,
  output logic [SLOTS*DW-1:0] data_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[g]              <= 1'b0;
        data_o[g*DW +: DW]     <= '0;
      end else if (clr_i) begin
        mask_o[g]              <= 1'b0;
        data_o[g*DW +: DW]     <= '0;
      end else if (we_i && slot_i == SW'(g)) begin
        mask_o[g]              <= 1'b1;
        data_o[g*DW +: DW]     <= data_i;
      end
    end
  end
endmodule

// File: rtl/ccr_wel_ctrl.sv
module ccr_wel_ctrl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [DW-1:0] data_i,
  output logic          wel_o,
  output logic          rwel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o  <= 1'b0;
      rwel_o <= 1'b0;
    end else if (upd_i) begin
      wel_o  <= data_i[1];
      rwel_o <= data_i[1] & data_i[2] & wel_o;
    end
  end
endmodule

// File: rtl/ccr_seq.sv
module ccr_seq
  import ccr_seq_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned DW    = 8,
  parameter int unsigned SLOTS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [7:0]          dev_i,
  input  logic                addr_valid_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                wdata_valid_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                rd_req_i,
  input  logic                stop_i,
  input  logic                abort_i,
  output logic [AW-1:0]       mem_raddr_o,
  input  logic [DW-1:0]       mem_rdata_i,
  output logic                rd_valid_o,
  output logic [DW-1:0]       rd_data_o,
  output logic                commit_o,
  output logic [AW-1:0]       commit_base_o,
  output logic [SLOTS-1:0]    commit_mask_o,
  output logic [SLOTS*DW-1:0] commit_data_o
);
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic          sel_q, rd_mode_q, dead_q, stat_pend_q, commit_q;
  logic [AW-1:0] ptr_q, buf_base_q;
  logic [DW-1:0] stat_byte_q, rd_q;
  logic          rd_valid_q;

  logic          dec_hit, dec_stat;
  logic [AW-1:0] dec_base, dec_next;
  logic [SW-1:0] dec_off;
  logic          wel_q, rwel_q;

  logic act, addr_fire, wr_fire, rd_fire, step, stop_fire, buf_clr, buf_we;
  logic [DW-1:0] stat_rd;

  ccr_sec_decode #(.AW(AW), .SW(SW)) i_dec (
    .addr_i    (ptr_q),
    .hit_o     (dec_hit),
    .is_stat_o (dec_stat),
    .base_o    (dec_base),
    .next_o    (dec_next),
    .off_o     (dec_off)
  );

  // event qualification: abort > start > stop > byte events
  assign act       = sel_q & ~abort_i & ~start_i & ~stop_i;
  assign addr_fire = act & addr_valid_i & ~rd_mode_q;
  assign wr_fire   = act & wdata_valid_i & ~addr_valid_i & ~rd_mode_q & ~dead_q;
  assign rd_fire   = act & rd_req_i & rd_mode_q & ~dead_q;
  assign step      = wr_fire | rd_fire;
  assign stop_fire = sel_q & stop_i & ~abort_i & ~start_i;
  assign buf_clr   = abort_i | start_i;
  assign buf_we    = wr_fire & dec_hit & ~dec_stat;

  ccr_wr_buf #(.SLOTS(SLOTS), .DW(DW), .SW(SW)) i_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (buf_clr),
    .we_i   (buf_we),
    .slot_i (dec_off),
    .data_i (wdata_i),
    .mask_o (commit_mask_o),
    .data_o (commit_data_o)
  );

  ccr_wel_ctrl #(.DW(DW)) i_wel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (stop_fire & stat_pend_q & ~rd_mode_q),
    .data_i (stat_byte_q),
    .wel_o  (wel_q),
    .rwel_o (rwel_q)
  );

  always_comb begin
    stat_rd    = '0;
    stat_rd[1] = wel_q;
    stat_rd[2] = rwel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= 1'b0;
      rd_mode_q   <= 1'b0;
      dead_q      <= 1'b0;
      stat_pend_q <= 1'b0;
      stat_byte_q <= '0;
      ptr_q       <= '0;
      buf_base_q  <= '0;
    end else if (abort_i) begin
      sel_q       <= 1'b0;
      stat_pend_q <= 1'b0;
    end else if (start_i) begin
      sel_q       <= (dev_i[7:1] == DEV_ID);
      rd_mode_q   <= dev_i[0];
      dead_q      <= 1'b0;
      stat_pend_q <= 1'b0;
    end else if (stop_fire) begin
      sel_q       <= 1'b0;
      stat_pend_q <= 1'b0;
    end else begin
      if (addr_fire) ptr_q <= addr_i;
      if (step) begin
        ptr_q <= dec_next;
        if (dec_stat) dead_q <= 1'b1;
      end
      if (buf_we) buf_base_q <= dec_base;
      if (wr_fire && dec_stat) begin
        stat_pend_q <= 1'b1;
        stat_byte_q <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q   <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_q       <= '0;
    end else begin
      commit_q   <= stop_fire & ~rd_mode_q & (|commit_mask_o) & rwel_q;
      rd_valid_q <= rd_fire;
      if (rd_fire) rd_q <= dec_stat ? stat_rd : (dec_hit ? mem_rdata_i : '0);
    end
  end

  assign mem_raddr_o   = ptr_q;
  assign rd_valid_o    = rd_valid_q;
  assign rd_data_o     = rd_q;
  assign commit_o      = commit_q;
  assign commit_base_o = buf_base_q;
endmodule

// File: rtl/ccr_seq_chk.sv
module ccr_seq_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stop_i,
  input logic          abort_i,
  input logic          commit_o,
  input logic [AW-1:0] commit_base_o,
  input logic          rd_valid_o,
  input logic [DW-1:0] rd_data_o,
  input logic          wel_q,
  input logic          rwel_q,
  input logic          step,
  input logic          dec_hit,
  input logic [AW-1:0] ptr_q
);
  assert_commit_on_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_i && !abort_i));

  assert_commit_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(rwel_q));

  assert_rwel_after_wel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rwel_q) |-> $past(wel_q));

  assert_abort_no_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !commit_o);

  assert_section_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && ptr_q == AW'(7)) |=> ptr_q == AW'(0));

  assert_no_status_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_base_o != AW'(63));

  assert_undef_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(!dec_hit)) |-> rd_data_o == '0);
endmodule

bind ccr_seq ccr_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stop_i        (stop_i),
  .abort_i       (abort_i),
  .commit_o      (commit_o),
  .commit_base_o (commit_base_o),
  .rd_valid_o    (rd_valid_o),
  .rd_data_o     (rd_data_o),
  .wel_q         (wel_q),
  .rwel_q        (rwel_q),
  .step          (step),
  .dec_hit       (dec_hit),
  .ptr_q         (ptr_q)
);

// File: tb/test_ccr_seq.sv
`timescale 1ns/1ps
module test_ccr_seq;
  localparam int AW = 6, DW = 8, SLOTS = 8;
  localparam logic [7:0] DEV_WR = 8'hDE, DEV_RD = 8'hDF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, addr_v = 0, wd_v = 0, rd_req = 0, stop = 0, abort = 0;
  logic [7:0] dev = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_rdata, rd_data;
  logic rd_valid, commit;
  logic [AW-1:0] cbase;
  logic [SLOTS-1:0] cmask;
  logic [SLOTS*DW-1:0] cdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // storage model: byte at address a is {2'b01, a}
  assign mem_rdata = {2'b01, mem_raddr};
  function automatic logic [7:0] f(logic [5:0] a); return {2'b01, a}; endfunction

  ccr_seq #(.AW(AW), .DW(DW), .SLOTS(SLOTS)) i_ccr_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_i(dev),
    .addr_valid_i(addr_v), .addr_i(addr), .wdata_valid_i(wd_v), .wdata_i(wd),
    .rd_req_i(rd_req), .stop_i(stop), .abort_i(abort),
    .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .commit_o(commit), .commit_base_o(cbase), .commit_mask_o(cmask),
    .commit_data_o(cdata)
  );

  task automatic chk(logic [63:0] act, logic [63:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    start = 0; addr_v = 0; wd_v = 0; rd_req = 0; stop = 0; abort = 0;
  endtask
  task automatic ev_start(logic [7:0] d); start = 1; dev = d; tick(); endtask
  task automatic ev_addr(logic [5:0] a); addr_v = 1; addr = a; tick(); endtask
  task automatic ev_wr(logic [7:0] d); wd_v = 1; wd = d; tick(); endtask
  task automatic ev_rd(); rd_req = 1; tick(); endtask
  task automatic ev_stop(); stop = 1; tick(); endtask
  task automatic ev_abort(); abort = 1; tick(); endtask

  task automatic set_ptr(logic [5:0] a);
    ev_start(DEV_WR); ev_addr(a); ev_stop();
  endtask
  task automatic wr_status(logic [7:0] d);
    ev_start(DEV_WR); ev_addr(6'h3F); ev_wr(d); ev_stop();
  endtask
  task automatic rd_status(logic [7:0] exp, string req);
    set_ptr(6'h3F); ev_start(DEV_RD); ev_rd();
    chk(rd_data, exp, req); ev_stop();
  endtask
  task automatic enable();
    wr_status(8'h02); wr_status(8'h06);
  endtask

  task automatic t_reset();
    chk(rd_valid, 0, "R11 rd_valid"); chk(commit, 0, "R11 commit");
    ev_start(DEV_RD); ev_rd();
    chk(rd_data, f(6'h00), "R11 pointer 0");
    ev_rd(); chk(rd_data, f(6'h01), "R3 increment");
    ev_stop();
    ev_start(DEV_RD); ev_rd(); chk(rd_data, f(6'h02), "R3 persist");
    ev_stop();
    rd_status(8'h00, "R11 enables clear");
  endtask

  task automatic t_wrap(logic [5:0] last, logic [5:0] first);
    set_ptr(last); chk(commit, 0, "R6 no data no commit");
    ev_start(DEV_RD); ev_rd(); chk(rd_data, f(last), "R2 last");
    ev_rd(); chk(rd_data, f(first), "R2 wrap");
    ev_stop();
  endtask

  task automatic t_gate();
    ev_start(DEV_WR); ev_addr(6'h10); ev_wr(8'h11); ev_stop();
    chk(commit, 0, "R5 no enable");
  endtask

  task automatic t_wel();
    wr_status(8'h06); rd_status(8'h02, "R8 rwel needs wel");
    wr_status(8'h06); rd_status(8'h06, "R7 both set");
    wr_status(8'h00); rd_status(8'h00, "R8 clear");
    enable(); rd_status(8'h06, "R8 two step");
  endtask

  task automatic t_page();
    ev_start(DEV_WR); ev_addr(6'h12);
    ev_wr(8'hA1); ev_wr(8'hA2); ev_wr(8'hA3); ev_stop();
    chk(commit, 1, "R6 commit");
    chk(cbase, 6'h10, "R6 base");
    chk(cmask, 8'h0D, "R2 wrap mask");
    chk(cdata, 64'h00000000A2A100A3, "R6 data");
    ev_start(DEV_RD); ev_rd(); chk(rd_data, f(6'h11), "R3 after write");
    ev_stop();
  endtask

  task automatic t_abort();
    ev_start(DEV_WR); ev_addr(6'h08); ev_wr(8'h55); ev_abort();
    chk(commit, 0, "R9 abort");
    ev_stop(); chk(commit, 0, "R9 stop after abort");
    ev_start(DEV_WR); ev_addr(6'h08); ev_wr(8'h55);
    stop = 1; abort = 1; tick();
    chk(commit, 0, "R9 abort wins over stop");
    ev_start(DEV_WR); ev_addr(6'h08); ev_wr(8'h66); ev_wr(8'h67); ev_stop();
    chk(commit, 1, "R6 after abort");
    chk(cmask, 8'h03, "R6 mask"); chk(cdata[15:0], 16'h6766, "R6 bytes");
  endtask

  task automatic t_status();
    ev_start(DEV_WR); ev_addr(6'h3F); ev_wr(8'h00); ev_wr(8'h06); ev_stop();
    chk(commit, 0, "R7 no status commit");
    rd_status(8'h00, "R4 second byte ignored");
    ev_start(DEV_RD); ev_rd(); chk(rd_valid, 1, "R4 first read");
    ev_rd(); chk(rd_valid, 0, "R4 second read");
    ev_stop();
    ev_start(DEV_RD); ev_rd(); chk(rd_valid, 1, "R4 pointer stays");
    chk(rd_data, 8'h00, "R4 value"); ev_stop();
  endtask

  task automatic t_undef();
    enable();
    ev_start(DEV_WR); ev_addr(6'h20); ev_wr(8'h77); ev_stop();
    chk(commit, 0, "R10 write dropped");
    set_ptr(6'h20); ev_start(DEV_RD); ev_rd();
    chk(rd_data, 8'h00, "R10 read zero"); chk(rd_valid, 1, "R10 valid");
    ev_stop();
  endtask

  task automatic t_select();
    ev_start(8'hA0); ev_addr(6'h05); ev_wr(8'h99); ev_stop();
    chk(commit, 0, "R1 foreign write");
    ev_start(DEV_RD); ev_rd();
    chk(rd_data, 8'h00, "R1 pointer untouched");
    ev_stop();
    ev_start(8'hA1); ev_rd(); chk(rd_valid, 0, "R1 foreign read");
    ev_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrap(6'h07, 6'h00);
    t_wrap(6'h13, 6'h10);
    t_wrap(6'h37, 6'h30);
    t_gate();
    t_wel();
    t_page();
    t_abort();
    t_status();
    t_undef();
    t_select();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule